// File: doc/BRIEF.md
# Coded Reference and Feedback Divider Pair

This block holds the two counting dividers of a single-modulus frequency synthesizer. The first divider runs on the reference oscillator clock. It divides by one of eight fixed ratios, chosen by a 3-bit selection code. The second divider runs on the clock derived from the voltage-controlled oscillator. It divides by a 14-bit value loaded in parallel. A transmit/receive select can add a fixed intermediate-frequency offset of 856 to that value.

Each divider produces a one-clock strobe once per division period, in its own clock domain. A phase detector outside the block compares the two strobes. The feedback strobe is also driven on a second output, so that the feedback divider can be used on its own.

Each divider counts down and reloads its programmed value. A change to the code or to the program word is therefore picked up only at the next reload. Both clock domains have a synchronous reset, and the two domains share no logic.

Top module: `synth_div_pair`

## Requirements
- R1: The reference code selects the reference ratio as follows: code 0 divides by 8, code 1 by 128, code 2 by 256, code 3 by 512, code 4 by 1024, code 5 by 2048, code 6 by 2410 and code 7 by 8192. Code 7 is the all-ones default.
- R2: The reference strobe is high for exactly one reference clock cycle in every period whose length is the selected ratio.
- R3: With `fb_add_n` high, the feedback strobe has a period equal to `fb_word` feedback clock cycles. Bit 0 of `fb_word` is the least significant bit and bit 13 the most significant.
- R4: With `fb_add_n` low, the feedback period is `fb_word + 856`.
- R5: If the offset sum exceeds 16383, it wraps modulo 16384.
- R6: An effective feedback value below 3 divides by 3. This covers program values 0 to 2, and a wrapped sum of 0.
- R7: A change of `ref_code`, `fb_word` or `fb_add_n` does not alter the period in progress. It first applies to the period that starts at the next strobe.
- R8: While a reset is high, that domain's strobe is low. The first strobe comes on the N-th rising edge after the last edge on which reset was sampled high, where N is the current divide value.
- R9: `fb_mon` always carries the same value as `fb_tick`.
- R10: No strobe lasts longer than one cycle of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock |
| ref_rst | input | 1 | Synchronous reset, reference domain, active high |
| ref_code | input | 3 | Reference ratio selection code |
| ref_tick | output | 1 | Divided reference strobe |
| fb_clk | input | 1 | Feedback input clock derived from the oscillator |
| fb_rst | input | 1 | Synchronous reset, feedback domain, active high |
| fb_word | input | 14 | Feedback divide program word |
| fb_add_n | input | 1 | Low adds the 856 offset to the program word |
| fb_tick | output | 1 | Divided feedback strobe |
| fb_mon | output | 1 | Buffered copy of the feedback strobe |

## Verification
A wrong count state or a wrong decoded divide value shows at the ports as a strobe interval of the wrong length. It becomes visible no later than the end of the period in which the fault occurs. A value latched at the wrong moment shows up as a period that takes the new value one period too early. Wrap or floor faults only show up for the program words near 16383 and near 0, so those words are driven directly.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
  localparam int CODE_W    = 3;
  localparam int FB_W      = 14;
  localparam int REF_MAX   = 8192;
  localparam int REF_W     = $clog2(REF_MAX);
  localparam int FB_OFFSET = 856;
  localparam int FB_MIN    = 3;

  // Reference ratio for a selection code (R1).
  function automatic int ref_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd6:    return 2410;
      3'd7:    return REF_MAX;
      default: return 64 << code;
    endcase
  endfunction

  // Terminal count (ratio minus one) loaded into the reference counter.
  function automatic logic [REF_W-1:0] ref_terminal(input logic [CODE_W-1:0] code);
    return REF_W'(ref_ratio(code) - 1);
  endfunction

  // Effective feedback divide value: optional offset with modulo wrap (R4, R5), then floor (R6).
  function automatic logic [FB_W-1:0] fb_value(input logic [FB_W-1:0] word, input logic add_n);
    logic [FB_W-1:0] sum;
    sum = add_n ? word : word + FB_W'(FB_OFFSET);
    if (sum < FB_W'(FB_MIN)) sum = FB_W'(FB_MIN);
    return sum;
  endfunction

  function automatic logic [FB_W-1:0] fb_terminal(input logic [FB_W-1:0] word, input logic add_n);
    return fb_value(word, add_n) - 1'b1;
  endfunction
endpackage

// File: rtl/sdiv_count.sv
`timescale 1ns/1ps
// Down counter with reload at zero and a registered one-cycle strobe.
module sdiv_count #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] term,
  output logic [W-1:0] cnt,
  output logic         reload,
  output logic         tick
);
  assign reload = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= term;
      tick <= 1'b0;
    end else if (reload) begin
      cnt  <= term;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sdiv_ref.sv
`timescale 1ns/1ps
module sdiv_ref
  import sdiv_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int RW = REF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] code,
  output logic [RW-1:0] term,
  output logic [RW-1:0] cnt,
  output logic          reload,
  output logic          tick
);
  assign term = RW'(ref_terminal(CODE_W'(code)));

  sdiv_count #(.W(RW)) u_cnt (
    .clk(clk), .rst(rst), .term(term), .cnt(cnt), .reload(reload), .tick(tick)
  );
endmodule

// File: rtl/sdiv_fb.sv
`timescale 1ns/1ps
module sdiv_fb
  import sdiv_pkg::*;
#(
  parameter int W = FB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word,
  input  logic         add_n,
  output logic [W-1:0] term,
  output logic [W-1:0] cnt,
  output logic         reload,
  output logic         tick
);
  assign term = W'(fb_terminal(FB_W'(word), add_n));

  sdiv_count #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .term(term), .cnt(cnt), .reload(reload), .tick(tick)
  );
endmodule

// File: rtl/synth_div_pair.sv
`timescale 1ns/1ps
module synth_div_pair
  import sdiv_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int FW = FB_W,
  parameter int RW = REF_W
) (
  input  logic          ref_clk,
  input  logic          ref_rst,
  input  logic [CW-1:0] ref_code,
  output logic          ref_tick,
  input  logic          fb_clk,
  input  logic          fb_rst,
  input  logic [FW-1:0] fb_word,
  input  logic          fb_add_n,
  output logic          fb_tick,
  output logic          fb_mon
);
  // Internal events brought out as named wires for the checker.
  logic [RW-1:0] ref_term, ref_cnt;
  logic          ref_reload;
  logic [FW-1:0] fb_term, fb_cnt;
  logic          fb_reload;

  sdiv_ref #(.CW(CW), .RW(RW)) u_ref (
    .clk(ref_clk), .rst(ref_rst), .code(ref_code),
    .term(ref_term), .cnt(ref_cnt), .reload(ref_reload), .tick(ref_tick)
  );

  sdiv_fb #(.W(FW)) u_fb (
    .clk(fb_clk), .rst(fb_rst), .word(fb_word), .add_n(fb_add_n),
    .term(fb_term), .cnt(fb_cnt), .reload(fb_reload), .tick(fb_tick)
  );

  assign fb_mon = fb_tick;
endmodule

// File: rtl/sdiv_chk.sv
`timescale 1ns/1ps
module sdiv_chk #(
  parameter int FW = 14,
  parameter int RW = 13,
  parameter int FMIN = 3
) (
  input logic          ref_clk,
  input logic          ref_rst,
  input logic          ref_tick,
  input logic [RW-1:0] ref_cnt,
  input logic          ref_reload,
  input logic          fb_clk,
  input logic          fb_rst,
  input logic          fb_tick,
  input logic [FW-1:0] fb_cnt,
  input logic [FW-1:0] fb_term,
  input logic          fb_reload
);
  // R10
  ref_strobe_width_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    ref_tick |=> !ref_tick);
  // R10
  fb_strobe_width_chk: assert property (@(posedge fb_clk) disable iff (fb_rst)
    fb_tick |=> !fb_tick);
  // R2
  ref_zero_fires_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    ref_reload |=> ref_tick);
  // R2
  ref_count_step_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (ref_cnt != '0) |=> (ref_cnt == $past(ref_cnt) - 1'b1) && !ref_tick);
  // R3
  fb_zero_fires_chk: assert property (@(posedge fb_clk) disable iff (fb_rst)
    fb_reload |=> fb_tick);
  // R3
  fb_count_step_chk: assert property (@(posedge fb_clk) disable iff (fb_rst)
    (fb_cnt != '0) |=> (fb_cnt == $past(fb_cnt) - 1'b1) && !fb_tick);
  // R7
  fb_reload_value_chk: assert property (@(posedge fb_clk) disable iff (fb_rst)
    fb_reload |=> fb_cnt == $past(fb_term));
  // R6
  fb_term_floor_chk: assert property (@(posedge fb_clk) disable iff (fb_rst)
    fb_term >= FW'(FMIN - 1));
  // R8
  ref_reset_quiet_chk: assert property (@(posedge ref_clk) ref_rst |=> !ref_tick);
  // R8
  fb_reset_quiet_chk: assert property (@(posedge fb_clk) fb_rst |=> !fb_tick);
endmodule

bind synth_div_pair sdiv_chk #(.FW(FW), .RW(RW), .FMIN(sdiv_pkg::FB_MIN)) u_chk (
  .ref_clk(ref_clk), .ref_rst(ref_rst), .ref_tick(ref_tick), .ref_cnt(ref_cnt),
  .ref_reload(ref_reload), .fb_clk(fb_clk), .fb_rst(fb_rst), .fb_tick(fb_tick),
  .fb_cnt(fb_cnt), .fb_term(fb_term), .fb_reload(fb_reload)
);

// File: tb/synth_div_pair_tb.sv
`timescale 1ns/1ps
module synth_div_pair_tb;
  logic        ref_clk = 1'b0, fb_clk = 1'b0;
  logic        ref_rst = 1'b1, fb_rst = 1'b1;
  logic [2:0]  ref_code = 3'b111;
  logic [13:0] fb_word = 14'h3fff;
  logic        fb_add_n = 1'b1;
  logic        ref_tick, fb_tick, fb_mon;
  int checks = 0, errors = 0, mon_bad = 0;
  bit done = 0;

  always #2.5 ref_clk = ~ref_clk;
  always #3.5 fb_clk = ~fb_clk;

  synth_div_pair u_dut (
    .ref_clk(ref_clk), .ref_rst(ref_rst), .ref_code(ref_code), .ref_tick(ref_tick),
    .fb_clk(fb_clk), .fb_rst(fb_rst), .fb_word(fb_word), .fb_add_n(fb_add_n),
    .fb_tick(fb_tick), .fb_mon(fb_mon)
  );

  function automatic int exp_ref(input int code);
    int table_v[8] = '{8, 128, 256, 512, 1024, 2048, 2410, 8192};
    return table_v[code];
  endfunction

  function automatic int exp_fb(input int word, input bit add_n);
    int s = word;
    if (!add_n) s = s + 856;
    while (s >= 16384) s = s - 16384;
    if (s < 3) s = 3;
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts reference negedges up to and including the next strobe.
  task automatic ref_period(output int n);
    n = 0;
    do begin @(negedge ref_clk); n++; end while (!ref_tick && n < 40000);
  endtask

  task automatic fb_period(output int n);
    n = 0;
    do begin
      @(negedge fb_clk); n++;
      if (fb_mon !== fb_tick) mon_bad++;
    end while (!fb_tick && n < 40000);
  endtask

  task automatic ref_seq();
    int n;
    int order[8] = '{0, 6, 1, 2, 3, 4, 5, 7};
    int prev;
    repeat (3) @(negedge ref_clk);
    chk("R8 ref strobe low in reset", int'(ref_tick), 0);
    ref_rst = 1'b0;
    ref_period(n);
    chk("R8 R1 ref first period default code", n, 8192);
    prev = 7;
    foreach (order[i]) begin
      ref_code = 3'(order[i]);
      ref_period(n);
      chk("R7 ref period after code change keeps old ratio", n, exp_ref(prev));
      ref_period(n);
      chk($sformatf("R1 R2 ref code %0d", order[i]), n, exp_ref(order[i]));
      prev = order[i];
    end
    ref_code = 3'd0;
    ref_period(n);
    ref_rst = 1'b1;
    @(negedge ref_clk); @(negedge ref_clk);
    chk("R8 ref strobe low in mid-run reset", int'(ref_tick), 0);
    ref_rst = 1'b0;
    ref_period(n);
    chk("R8 ref first period after reset", n, 8);
    ref_period(n);
    chk("R10 R2 ref steady period code 0", n, 8);
  endtask

  task automatic fb_case(input int word, input bit add_n, input string tag);
    int n, old_exp;
    old_exp = exp_fb(int'(fb_word), fb_add_n);
    fb_word = 14'(word);
    fb_add_n = add_n;
    fb_period(n);
    chk("R7 fb period after program change keeps old value", n, old_exp);
    fb_period(n);
    chk(tag, n, exp_fb(word, add_n));
  endtask

  task automatic fb_seq();
    int n;
    repeat (3) @(negedge fb_clk);
    chk("R8 fb strobe low in reset", int'(fb_tick), 0);
    fb_rst = 1'b0;
    fb_period(n);
    chk("R8 R3 fb first period default word", n, 16383);
    fb_case(5, 1'b1, "R3 fb word 5");
    fb_case(3, 1'b1, "R3 fb minimum word 3");
    fb_case(2, 1'b1, "R6 fb word 2 floors to 3");
    fb_case(0, 1'b1, "R6 fb word 0 floors to 3");
    fb_case(100, 1'b0, "R4 fb word 100 with offset");
    fb_case(0, 1'b0, "R4 fb word 0 with offset");
    fb_case(16000, 1'b0, "R5 fb offset sum wraps");
    fb_case(15528, 1'b0, "R5 R6 fb wrapped sum 0 floors to 3");
    fb_case(14'h2aaa, 1'b1, "R3 fb bit order word 0x2aaa");
    for (int i = 0; i < 20; i++) begin
      int w = 3 + int'($urandom % 1500);
      bit a = 1'(($urandom >> 4) & 1);
      fb_case(w, a, a ? "R3 fb random word" : "R4 fb random word with offset");
    end
    fb_word = 14'd40;
    fb_add_n = 1'b1;
    fb_rst = 1'b1;
    @(negedge fb_clk); @(negedge fb_clk);
    chk("R8 fb strobe low in mid-run reset", int'(fb_tick), 0);
    fb_rst = 1'b0;
    fb_period(n);
    chk("R8 fb first period after reset", n, 40);
    fb_period(n);
    chk("R10 R3 fb steady period 40", n, 40);
  endtask

  initial begin
    int seed_v;
    seed_v = int'($urandom(32'd2024));
    fork
      ref_seq();
      fb_seq();
    join
    chk("R9 fb_mon equals fb_tick mismatches", mon_bad, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #900us;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule